// File: doc/BRIEF.md
# Parallel Bus Register Write Sequencer

This block takes a request from the host to write a small register inside one of four remote logic devices. The request arrives over a valid/ready handshake and carries a device number, a register offset and a data value. The block places the request on a shared 32-bit parallel output bus in two timed phases.

In the first phase the offset and the data are driven and every device enable is low. After a setup interval measured in clock cycles, the second phase keeps the same offset and data and raises the enable of the target device alone. The enables are carried as one-hot bits in the upper part of a 7-bit address field.

Bus bits outside the address and data fields are not touched by writes. They follow a background input that belongs to other logic. A request that names a device outside 1 to 4 is refused with a one-cycle error pulse and leaves the bus as it was.

Top module: `busreg_wr_seq`

## Requirements
- R1: After reset the address field (bus[15:9]) and the data field (bus[31:27]) are zero, `req_ready` is high and `wr_err` is low.
- R2: Field layout. `bus_out[31:27]` carries the 5-bit data. `bus_out[15:9]` is {EN1, EN2, EN3, EN4, OFF[2:0]}, with the enable of device 1 in bit 15 and the enable of device 4 in bit 12.
- R3: `req_dev` is a 3-bit binary device number, and only values 1 to 4 are valid. In the cycle after a valid request is accepted, the bus carries the new offset and data with all four enable bits at zero.
- R4: The enables-off phase lasts exactly GAP cycles, where GAP = max(1, ceil(SETUP_NS × CLK_MHZ / 1000)). With the defaults (166 ns, 125 MHz) GAP is 21.
- R5: After the setup phase exactly one enable is set, the one that belongs to the requested device. Offset and data stay unchanged. At no time is more than one enable bit set.
- R6: `req_ready` is low from the edge that accepts a valid request through the first cycle of the enable phase, and it is high again in the cycle after that.
- R7: A request with `req_dev` equal to 0, 5, 6 or 7 produces a `wr_err` pulse one cycle long in the cycle after acceptance. The address and data fields do not change and `req_ready` stays high.
- R8: Bus bits outside the two fields always equal the matching bits of `bg_bits`.
- R9: After the enable phase the fields hold their values, with the enable still set, until the next valid request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request will be accepted |
| req_dev | input | 3 | Target device number, binary, valid range 1 to 4 |
| req_off | input | 3 | Register offset inside the device |
| req_data | input | 5 | Value to write |
| bg_bits | input | 32 | Value for the bus bits that writes do not own |
| bus_out | output | 32 | Parallel output bus |
| wr_err | output | 1 | One-cycle pulse for a refused device number |

## Verification
Two conditions are hard to reach from the ports. The first is the exact edge where the setup phase ends: the output must hold the enables-off pattern at the last setup cycle and show the enable one cycle later. The bench samples both of those cycles for every offset and data value, so an early or late enable is caught. The second is an invalid request that follows a completed write. That case needs a set enable and real field contents in place, so the sweep interleaves the invalid device numbers with valid writes and compares the bus against the previous write's value.

// File: rtl/busreg_pkg.sv
package busreg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SETUP = 2'd1,
    ST_STROBE = 2'd2
  } seq_state_t;

  // setup gap in cycles: ceil(ns * MHz / 1000), never below one
  function automatic int gap_cycles(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/busreg_gap_timer.sv
module busreg_gap_timer #(
  parameter int GAP = 21
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire
);
  localparam int CW = $clog2(GAP + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= CW'(GAP);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  // high in the last cycle of the interval
  assign expire = (cnt == CW'(1));
endmodule

// File: rtl/busreg_field_pack.sv
module busreg_field_pack #(
  parameter int BUS_W    = 32,
  parameter int ADDR_LSB = 9,
  parameter int DATA_LSB = 27,
  parameter int N_DEV    = 4,
  parameter int OFF_W    = 3,
  parameter int DATA_W   = 5
) (
  input  logic [N_DEV-1:0]  en,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] data,
  input  logic [BUS_W-1:0]  bg,
  output logic [BUS_W-1:0]  bus
);
  localparam int ADDR_W = N_DEV + OFF_W;

  function automatic logic [BUS_W-1:0] field_mask();
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < ADDR_W; i++) m[ADDR_LSB+i] = 1'b1;
    for (int i = 0; i < DATA_W; i++) m[DATA_LSB+i] = 1'b1;
    return m;
  endfunction

  localparam logic [BUS_W-1:0] MASK = field_mask();

  logic [BUS_W-1:0] owned;

  always_comb begin
    owned = '0;
    owned[ADDR_LSB +: ADDR_W] = {en, off};
    owned[DATA_LSB +: DATA_W] = data;
    bus = (bg & ~MASK) | owned;
  end
endmodule

// File: rtl/busreg_wr_seq.sv
module busreg_wr_seq
  import busreg_pkg::*;
#(
  parameter int BUS_W    = 32,
  parameter int ADDR_LSB = 9,
  parameter int DATA_LSB = 27,
  parameter int N_DEV    = 4,
  parameter int OFF_W    = 3,
  parameter int DATA_W   = 5,
  parameter int CLK_MHZ  = 125,
  parameter int SETUP_NS = 166
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_dev,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [DATA_W-1:0] req_data,
  input  logic [BUS_W-1:0]  bg_bits,
  output logic [BUS_W-1:0]  bus_out,
  output logic              wr_err
);
  localparam int GAP  = gap_cycles(SETUP_NS, CLK_MHZ);
  localparam int OBSW = $clog2(GAP + 1);

  function automatic logic dev_ok(input logic [2:0] d);
    return (d >= 3'd1) && (int'(d) <= N_DEV);
  endfunction

  // device 1 maps to the most significant enable bit
  function automatic logic [N_DEV-1:0] dev_sel(input logic [2:0] d);
    logic [N_DEV-1:0] r;
    r = '0;
    for (int i = 0; i < N_DEV; i++) r[N_DEV-1-i] = (int'(d) == i + 1);
    return r;
  endfunction

  seq_state_t        state;
  logic [N_DEV-1:0]  en_q, tgt_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  // named events
  logic accept, accept_good, accept_bad, gap_expire, go_strobe;

  assign req_ready   = (state == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign accept_good = accept && dev_ok(req_dev);
  assign accept_bad  = accept && !dev_ok(req_dev);
  assign go_strobe   = (state == ST_SETUP) && gap_expire;

  busreg_gap_timer #(.GAP(GAP)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept_good),
    .expire (gap_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      en_q   <= '0;
      tgt_q  <= '0;
      off_q  <= '0;
      data_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept_bad;
      unique case (state)
        ST_IDLE: if (accept_good) begin
          en_q   <= '0;
          tgt_q  <= dev_sel(req_dev);
          off_q  <= req_off;
          data_q <= req_data;
          state  <= ST_SETUP;
        end
        ST_SETUP: if (go_strobe) begin
          en_q  <= tgt_q;
          state <= ST_STROBE;
        end
        ST_STROBE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  busreg_field_pack #(
    .BUS_W(BUS_W), .ADDR_LSB(ADDR_LSB), .DATA_LSB(DATA_LSB),
    .N_DEV(N_DEV), .OFF_W(OFF_W), .DATA_W(DATA_W)
  ) u_pack (
    .en   (en_q),
    .off  (off_q),
    .data (data_q),
    .bg   (bg_bits),
    .bus  (bus_out)
  );

  assign wr_err = err_q;

  // cycles since the last good acceptance, saturating, for the gap check
  logic [OBSW-1:0] obs_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) obs_cnt <= '0;
    else if (accept_good) obs_cnt <= '0;
    else if (obs_cnt != OBSW'(GAP)) obs_cnt <= obs_cnt + 1'b1;
  end

  logic [N_DEV-1:0] en_bus;
  assign en_bus = bus_out[ADDR_LSB+OFF_W +: N_DEV];

  // R3
  phase1_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_good |=> (en_bus == '0) && (bus_out[ADDR_LSB +: OFF_W] == $past(req_off))
                    && (bus_out[DATA_LSB +: DATA_W] == $past(req_data)));

  // R4
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|en_bus) |-> (obs_cnt >= OBSW'(GAP)));

  // R5
  single_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_bus));

  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_good |=> !req_ready);

  // R7
  bad_dev_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $stable(en_q) && $stable(off_q) && $stable(data_q));
endmodule

// File: tb/sim_busreg_wr_seq.sv
module sim_busreg_wr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_dev = '0;
  logic [2:0]  req_off = '0;
  logic [4:0]  req_data = '0;
  logic [31:0] bg_bits = '0;
  logic [31:0] bus_out;
  logic        wr_err;

  localparam int GAP = (166 * 125 + 999) / 1000;
  localparam logic [31:0] OWNED = 32'hF800_FE00;

  int vecs = 0;
  int bad  = 0;
  logic [6:0] cur_addr = '0;
  logic [4:0] cur_data = '0;

  always #4 clk = ~clk;

  busreg_wr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dev(req_dev), .req_off(req_off), .req_data(req_data),
    .bg_bits(bg_bits), .bus_out(bus_out), .wr_err(wr_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_fields(input string req, input logic [6:0] a, input logic [4:0] d);
    chk(req, {25'd0, bus_out[15:9]}, {25'd0, a});
    chk(req, {27'd0, bus_out[31:27]}, {27'd0, d});
    chk({req, "/R8"}, bus_out & ~OWNED, bg_bits & ~OWNED);
  endtask

  task automatic do_write(input int dev, input int off, input int dat);
    logic [3:0] en;
    en = 4'b1000 >> (dev - 1);
    @(negedge clk);
    bg_bits   = $urandom;
    req_valid = 1'b1;
    req_dev   = 3'(dev);
    req_off   = 3'(off);
    req_data  = 5'(dat);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (dev < 1 || dev > 4) begin
      // R7: refused, error pulse, fields kept
      chk("R7 err", {31'd0, wr_err}, 32'd1);
      chk("R7 ready", {31'd0, req_ready}, 32'd1);
      chk_fields("R7 hold", cur_addr, cur_data);
      @(negedge clk);
      chk("R7 pulse", {31'd0, wr_err}, 32'd0);
      chk_fields("R7 hold2", cur_addr, cur_data);
    end else begin
      // R3 first setup cycle, R6 busy
      chk_fields("R3", {4'b0, 3'(off)}, 5'(dat));
      chk("R6 busy", {31'd0, req_ready}, 32'd0);
      repeat (GAP - 1) @(negedge clk);
      // R4 last setup cycle, still no enable
      chk_fields("R4", {4'b0, 3'(off)}, 5'(dat));
      @(negedge clk);
      // R5 R2 enable phase
      chk_fields("R5", {en, 3'(off)}, 5'(dat));
      chk("R6 strobe", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
      chk("R6 free", {31'd0, req_ready}, 32'd1);
      cur_addr = {en, 3'(off)};
      cur_data = 5'(dat);
      // R9 hold after the enable phase
      chk_fields("R9", cur_addr, cur_data);
    end
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk_fields("R1", 7'd0, 5'd0);
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 err", {31'd0, wr_err}, 32'd0);
    // R2: device 1 lands in bit 15, device 4 in bit 12
    do_write(1, 0, 0);
    chk("R2 dev1", {31'd0, bus_out[15]}, 32'd1);
    do_write(4, 0, 0);
    chk("R2 dev4", {31'd0, bus_out[12]}, 32'd1);
    for (int d = 0; d < 8; d++)
      for (int o = 0; o < 8; o++)
        for (int v = 0; v < 32; v++)
          do_write(d, o, (v + 3 * o + d) % 32);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule